// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Word Serializer

This block takes a parallel address-event word from a four-phase request/acknowledge handshake and sends it one bit per bit slot over two wires: a data rail and a parity rail. No clock travels with the bits. A receiver finds each new bit because the relation between the two rails flips. In odd-phase slots the parity rail is the complement of the data rail. In even-phase slots the two rails are equal. The data rail always carries the bit value itself.

Each word is wrapped in a wake window. The wake output rises at the start of a word and falls when the word ends, so any line drivers it controls are only on while a word is in flight. At the start of the window there is a programmable wake delay. During that delay the rails keep showing the previous word's least significant bit with both rails equal, which gives the far end time to settle before the first real bit arrives. The length of each bit slot is also programmable. Both counts are taken from configuration inputs at the start of each word.

Top module: `ledr_word_tx`

## Requirements
- R1: After reset the data and parity rails are both 0, and wake and acknowledge are both low.
- R2: Bits go out most significant first, one per slot. In every slot the data rail equals the bit. With bit 0 counted as the first bit sent, even-numbered bits (odd phase, including the first) put the complement on the parity rail, and odd-numbered bits (even phase) put the bit itself on the parity rail.
- R3: Wake rises on the first clock edge at which request is sampled high while the block is idle.
- R4: The first bit appears on the rails N edges after wake rises, where N is the wake-delay input sampled at word start; a value of 0 acts as 1.
- R5: Throughout the wake delay, both rails hold the least significant bit of the previous word (0 after reset).
- R6: Each bit holds for B cycles, where B is the bit-cycle input sampled at word start; a value of 0 acts as 1.
- R7: Acknowledge rises, and wake falls, B cycles after the last bit is driven. Acknowledge falls on the first edge at which request is sampled low.
- R8: Changing the wake-delay or bit-cycle inputs while a word is in flight has no effect on that word's timing.
- R9: The word width is even, so once a word ends both rails equal its least significant bit. They keep that value until the next word's first bit.
- R10: While acknowledge is high and request stays high, no new word starts: wake stays low and the rails do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Four-phase request; word is valid while high |
| word_i | input | WIDTH | Parallel word to send |
| wake_cycles_i | input | CFG_W | Wake delay in cycles (0 acts as 1) |
| bit_cycles_i | input | CFG_W | Bit slot length in cycles (0 acts as 1) |
| ack_o | output | 1 | Four-phase acknowledge |
| wake_o | output | 1 | High for the duration of a word |
| data_o | output | 1 | Data rail |
| parity_o | output | 1 | Parity rail |

## Verification
Words are sent under several input patterns. Alternating bits, all ones, all zeros and mixed values tell a wrong phase rule apart from a wrong bit order, and they also expose a data rail that never toggles. Words whose least significant bits differ from one word to the next check whether the preamble really repeats the previous word's bit rather than a constant. Zero, minimum and larger delay counts, plus a word where the counts change mid-flight, separate correct slot timing and start-of-word sampling from off-by-one or live-input errors. A request held high past acknowledge checks that no word restarts before the handshake has completed.

// File: rtl/ledr_tx_pkg.sv
package ledr_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAKE = 2'd1,
        ST_SEND = 2'd2,
        ST_DONE = 2'd3
    } tx_state_e;

    // Zero count is treated as a count of one
    function automatic logic [7:0] at_least_one(input logic [7:0] v);
        return (v == 8'd0) ? 8'd1 : v;
    endfunction

endpackage

// File: rtl/ledr_tx_timer.sv
module ledr_tx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (val_i == '0) ? CNT_W'(1) : val_i;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == CNT_W'(1));

    // R6
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q != '0));

endmodule

// File: rtl/ledr_tx_rail_enc.sv
module ledr_tx_rail_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic bit_i,
    input  logic odd_i,
    output logic data_o,
    output logic parity_o
);
    typedef struct packed {
        logic data;
        logic parity;
    } rails_t;

    rails_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.data   = bit_i;
            r_d.parity = odd_i ? ~bit_i : bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o   = r_q.data;
    assign parity_o = r_q.parity;

    // R6
    rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(r_q));

endmodule

// File: rtl/ledr_word_tx.sv
module ledr_word_tx
    import ledr_tx_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic [CFG_W-1:0] wake_cycles_i,
    input  logic [CFG_W-1:0] bit_cycles_i,
    output logic             ack_o,
    output logic             wake_o,
    output logic             data_o,
    output logic             parity_o
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(WIDTH - 1);

    generate
        if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
            $error("ledr_word_tx: WIDTH must be even and at least 2");
        end
    endgenerate

    typedef struct packed {
        tx_state_e        st;
        logic [WIDTH-1:0] word;
        logic [CFG_W-1:0] bit_cfg;
        logic [IDX_W-1:0] idx;
        logic             wake;
        logic             ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load;
    logic [CFG_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             enc_load;
    logic [IDX_W-1:0] enc_idx;
    logic             enc_bit;
    logic             enc_odd;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = ctl_q.bit_cfg;
        enc_load = 1'b0;
        enc_idx  = ctl_q.idx;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st      = ST_WAKE;
                    ctl_d.word    = word_i;
                    ctl_d.bit_cfg = bit_cycles_i;
                    ctl_d.wake    = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = wake_cycles_i;
                end
            end
            ST_WAKE: begin
                if (tmr_expire) begin
                    ctl_d.st  = ST_SEND;
                    ctl_d.idx = MSB_IDX;
                    tmr_load  = 1'b1;
                    enc_load  = 1'b1;
                    enc_idx   = MSB_IDX;
                end
            end
            ST_SEND: begin
                if (tmr_expire) begin
                    if (ctl_q.idx == '0) begin
                        ctl_d.st   = ST_DONE;
                        ctl_d.ack  = 1'b1;
                        ctl_d.wake = 1'b0;
                    end else begin
                        ctl_d.idx = ctl_q.idx - IDX_W'(1);
                        tmr_load  = 1'b1;
                        enc_load  = 1'b1;
                        enc_idx   = ctl_q.idx - IDX_W'(1);
                    end
                end
            end
            ST_DONE: begin
                if (!req_i) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.ack = 1'b0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        enc_bit = ctl_d.word[enc_idx];
        // Even width: the MSB has an odd index and is sent in odd phase
        enc_odd = enc_idx[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, word: '0, bit_cfg: '0, idx: '0,
                       wake: 1'b0, ack: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ledr_tx_timer #(.CNT_W(CFG_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .val_i    (tmr_val),
        .expire_o (tmr_expire)
    );

    ledr_tx_rail_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (enc_load),
        .bit_i    (enc_bit),
        .odd_i    (enc_odd),
        .data_o   (data_o),
        .parity_o (parity_o)
    );

    assign ack_o  = ctl_q.ack;
    assign wake_o = ctl_q.wake;

    // R7
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> ($past(req_i) && $fell(wake_o)));

    // R7
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !$past(req_i));

    // R3
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(req_i));

    // R10
    wake_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_o && ack_o));

    // R5
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAKE) |-> (data_o == parity_o));

    // R2
    phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SEND) |->
            ((data_o == ctl_q.word[ctl_q.idx]) &&
             (parity_o == (ctl_q.idx[0] ? ~data_o : data_o))));

    // R9
    idle_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> (data_o == parity_o));

endmodule

// File: tb/ledr_word_tx_tb.sv
module ledr_word_tx_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0;
    logic [W-1:0] word_i = '0;
    logic [7:0]   wake_cycles_i = 8'd0;
    logic [7:0]   bit_cycles_i = 8'd0;
    logic         ack_o, wake_o, data_o, parity_o;

    int n_chk = 0;
    int n_bad = 0;
    logic prev_lsb = 1'b0;

    always #4 clk = ~clk;

    ledr_word_tx #(.WIDTH(W), .CFG_W(8)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .word_i        (word_i),
        .wake_cycles_i (wake_cycles_i),
        .bit_cycles_i  (bit_cycles_i),
        .ack_o         (ack_o),
        .wake_o        (wake_o),
        .data_o        (data_o),
        .parity_o      (parity_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Outputs packed as {ack, wake, data, parity}
    function automatic logic [3:0] outs();
        return {ack_o, wake_o, data_o, parity_o};
    endfunction

    task automatic send_word(input logic [W-1:0] w, input int n, input int b,
                             input bit chg_cfg, input string tag);
        int nn = (n == 0) ? 1 : n;
        int bb = (b == 0) ? 1 : b;
        int total = nn + W * bb;
        @(negedge clk);
        word_i        = w;
        wake_cycles_i = 8'(n);
        bit_cycles_i  = 8'(b);
        req_i         = 1'b1;
        @(negedge clk);
        for (int c = 0; c <= total; c++) begin
            logic [3:0] exp;
            if (chg_cfg && c == 0) begin
                // R8: live config changes must not affect this word
                wake_cycles_i = 8'(n + 5);
                bit_cycles_i  = 8'(b + 3);
                word_i        = ~w;
            end
            if (c < nn) begin
                // R3, R4, R5
                exp = {1'b0, 1'b1, prev_lsb, prev_lsb};
                chk({tag, " R5 preamble"}, 32'(outs()), 32'(exp));
            end else if (c < total) begin
                int i = (c - nn) / bb;
                logic bv = w[W-1-i];
                // R2, R6
                exp = {1'b0, 1'b1, bv, ((i % 2) == 0) ? ~bv : bv};
                chk({tag, " R2 bit slot"}, 32'(outs()), 32'(exp));
            end else begin
                // R7, R9
                exp = {1'b1, 1'b0, w[0], w[0]};
                chk({tag, " R7 ack rise"}, 32'(outs()), 32'(exp));
            end
            @(negedge clk);
        end
        // R10: request still high, no new word
        for (int k = 0; k < 3; k++) begin
            chk({tag, " R10 hold"}, 32'(outs()), 32'({1'b1, 1'b0, w[0], w[0]}));
            @(negedge clk);
        end
        req_i = 1'b0;
        @(negedge clk);
        // R7 ack falls, R9 rails keep LSB
        chk({tag, " R7 ack fall"}, 32'(outs()), 32'({1'b0, 1'b0, w[0], w[0]}));
        @(negedge clk);
        chk({tag, " R9 idle"}, 32'(outs()), 32'({1'b0, 1'b0, w[0], w[0]}));
        prev_lsb = w[0];
        wake_cycles_i = 8'd0;
        bit_cycles_i  = 8'd0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 32'(outs()), 32'h0);
        repeat (3) @(negedge clk);
        chk("R1 idle no req", 32'(outs()), 32'h0);
    endtask

    task automatic test_alternating();
        send_word(32'hAAAA_AAAB, 2, 1, 1'b0, "alt");
    endtask

    task automatic test_zero_counts();
        send_word(32'hFFFF_FFFE, 0, 0, 1'b0, "zero");
    endtask

    task automatic test_long_counts();
        send_word(32'h1234_5679, 4, 3, 1'b0, "long");
    endtask

    task automatic test_cfg_change();
        send_word(32'hC3A5_0F00, 3, 2, 1'b1, "chg R8");
    endtask

    task automatic test_all_ones();
        send_word(32'hFFFF_FFFF, 1, 2, 1'b0, "ones");
    endtask

    initial begin
        test_reset();
        test_alternating();
        test_zero_counts();
        test_long_counts();
        test_cfg_change();
        test_all_ones();
        send_word(32'h0000_0000, 2, 1, 1'b0, "zeros");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule